// File: doc/BRIEF.md
# Flash Completion Polling Controller

This block runs on the host side of a parallel flash device. Once the host has sent the command sequence for a program or an erase, it starts the controller with the operation type, the target address and the data that was written. The controller then finds out when the embedded operation has finished. It does not wait a fixed worst-case delay. It reads the device's status protocol repeatedly until that protocol reports completion.

Three methods can be selected. The first is complement-bit polling on data bit 7, with one extra confirming read. The second is toggle-bit checking on data bit 6 across consecutive reads. The third watches a ready/busy line, which passes through a synchronizer first, and issues no reads at all.

Status reads always target the latched address. That address must lie in the busy bank, because a read from any other bank returns array contents. Each read uses a request/acknowledge handshake on a generic memory port. A programmable poll budget limits how long the controller waits. When the budget runs out, the controller ends with a timeout flag set. Every run ends with a single-cycle done pulse.

Top module: `flash_poll_ctrl`

## Requirements
- R1: `start_i` is accepted only while `busy_o` is low. A start is ignored while a run is in progress, and its address, mode and limit have no effect on that run. `busy_o` goes high in the cycle after the start is accepted.
- R2: A status read holds `rd_req_o` high until it is acknowledged by `rd_ack_i`. Throughout the read, `rd_addr_o` equals the address captured at start. After each acknowledge, `rd_req_o` stays low for at least one cycle.
- R3: Mode 0 (`mode_i`=2'b00) with `op_i`=0 (program): a read counts as a match when its bit 7 equals bit 7 of `exp_data_i`. No other data bit matters.
- R4: Mode 0 with `op_i`=1 (erase): a read counts as a match when its bit 7 is 1. `exp_data_i` is ignored.
- R5: In mode 0, the run completes only on the second of two consecutive matching reads. A non-matching read after a match restarts the confirmation.
- R6: Mode 1 (`mode_i`=2'b01): the run completes on the first read whose bit 6 equals bit 6 of the previous read in the same run. The first read of a run never completes it.
- R7: Modes 2 and 3 (`mode_i[1]`=1): no read is issued. The run completes once the synchronized `ready_i` is high. With two synchronizer stages, if `ready_i` rises in the cycle r after start, done is visible r+3 cycles after the start edge.
- R8: A run uses at most max(`max_polls_i`,1) polls. A poll is one acknowledged read, or one cycle of sampled low ready in ready/busy mode. If the budget runs out without completion, the run ends with `timeout_o`=1. If the last allowed poll completes the run, the run ends as a success.
- R9: `done_o` is high for exactly one cycle at the end of every run. `timeout_o` is 0 after a successful run and 1 after a timed-out run. It holds that value until the next accepted start.
- R10: After reset, `busy_o`, `done_o`, `timeout_o` and `rd_req_o` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a polling run |
| op_i | input | 1 | Operation: 0 program, 1 erase |
| mode_i | input | 2 | Method: 00 bit-7 polling, 01 bit-6 toggle, 1x ready/busy |
| addr_i | input | AW (22) | Status read address, inside the busy bank |
| exp_data_i | input | DW (16) | Data that was programmed |
| max_polls_i | input | CW (16) | Poll budget (0 behaves as 1) |
| rd_req_o | output | 1 | Read request, held until acknowledged |
| rd_addr_o | output | AW (22) | Read address |
| rd_ack_i | input | 1 | Read acknowledge, data valid |
| rd_data_i | input | DW (16) | Read data |
| ready_i | input | 1 | Ready/busy line, high when ready |
| busy_o | output | 1 | A run is in progress |
| done_o | output | 1 | One-cycle end-of-run pulse |
| timeout_o | output | 1 | The last run ended by exhausting its budget |

## Verification
The assertions assume that the memory side acknowledges only while a request is pending and for a single cycle each time. The stimulus responder follows this rule: it waits for a pending request, adds a random delay of zero to two cycles, then pulses the acknowledge once.

The ready/busy checks assume that `ready_i` is already low for several cycles before the start, so that the synchronizer does not deliver a stale ready level. The bench lowers the line four cycles ahead of every ready/busy start.

Random data sequences cover status patterns with busy prefixes, single-read glitches and random poll budgets. The expected read count and outcome for each sequence come from a bench model of the status rules.

// File: rtl/flash_poll_pkg.sv
package flash_poll_pkg;
  localparam int unsigned POLL_BIT   = 7;
  localparam int unsigned TOGGLE_BIT = 6;

  localparam logic [1:0] MODE_DPOLL  = 2'b00;
  localparam logic [1:0] MODE_TOGGLE = 2'b01;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_REQ,
    ST_GAP,
    ST_RBWAIT
  } poll_state_e;
endpackage

// File: rtl/fp_sync.sv
module fp_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] pipe_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) pipe_q <= '0;
        else         pipe_q <= d_i;
      end
    end else begin : g_many
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) pipe_q <= '0;
        else         pipe_q <= {pipe_q[STAGES-2:0], d_i};
      end
    end
  endgenerate

  assign q_o = pipe_q[STAGES-1];
endmodule

// File: rtl/fp_status_eval.sv
module fp_status_eval
  import flash_poll_pkg::*;
#(
  parameter int unsigned DW = 16
) (
  input  logic [DW-1:0] data_i,
  input  logic          toggle_mode_i,
  input  logic          erase_i,
  input  logic          exp_bit_i,
  input  logic          prev_valid_i,
  input  logic          prev_bit_i,
  input  logic          confirm_i,
  output logic          hit_o,
  output logic          finish_o
);
  logic dp_hit, tg_hit;

  always_comb begin
    // erase drives bit 7 to 1 when finished; program drives it to the true data
    dp_hit   = erase_i ? data_i[POLL_BIT] : (data_i[POLL_BIT] == exp_bit_i);
    tg_hit   = prev_valid_i && (data_i[TOGGLE_BIT] == prev_bit_i);
    hit_o    = toggle_mode_i ? tg_hit : dp_hit;
    finish_o = toggle_mode_i ? tg_hit : (dp_hit && confirm_i);
  end
endmodule

// File: rtl/fp_poll_counter.sv
module fp_poll_counter #(
  parameter int unsigned CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clear_i,
  input  logic          tick_i,
  input  logic [CW-1:0] limit_i,
  output logic          expire_o
);
  localparam int unsigned XW = CW + 1;

  logic [CW-1:0] cnt_q;
  logic [XW-1:0] cnt_next;

  assign cnt_next = {1'b0, cnt_q} + XW'(1);
  // zero limit expires on the first tick, same as a limit of one
  assign expire_o = cnt_next >= {1'b0, limit_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 cnt_q <= '0;
    else if (clear_i)            cnt_q <= '0;
    else if (tick_i && !expire_o) cnt_q <= cnt_next[CW-1:0];
  end
endmodule

// File: rtl/flash_poll_ctrl.sv
module flash_poll_ctrl
  import flash_poll_pkg::*;
#(
  parameter int unsigned AW          = 22,
  parameter int unsigned DW          = 16,
  parameter int unsigned CW          = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          op_i,
  input  logic [1:0]    mode_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] exp_data_i,
  input  logic [CW-1:0] max_polls_i,
  output logic          rd_req_o,
  output logic [AW-1:0] rd_addr_o,
  input  logic          rd_ack_i,
  input  logic [DW-1:0] rd_data_i,
  input  logic          ready_i,
  output logic          busy_o,
  output logic          done_o,
  output logic          timeout_o
);
  poll_state_e   state_q, state_d;
  logic [1:0]    mode_q;
  logic          erase_q, exp_bit_q;
  logic [AW-1:0] addr_q;
  logic [CW-1:0] limit_q;
  logic          confirm_q, prev_valid_q, prev_bit_q;
  logic          done_q, timeout_q;

  logic rdy_sync, accept, ack, poll_tick, expire;
  logic hit, eval_finish, finish_ok, finish_to;

  fp_sync #(.STAGES(SYNC_STAGES)) u_rdy_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (ready_i),
    .q_o   (rdy_sync)
  );

  fp_status_eval #(.DW(DW)) u_eval (
    .data_i       (rd_data_i),
    .toggle_mode_i(mode_q == MODE_TOGGLE),
    .erase_i      (erase_q),
    .exp_bit_i    (exp_bit_q),
    .prev_valid_i (prev_valid_q),
    .prev_bit_i   (prev_bit_q),
    .confirm_i    (confirm_q),
    .hit_o        (hit),
    .finish_o     (eval_finish)
  );

  fp_poll_counter #(.CW(CW)) u_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (accept),
    .tick_i  (poll_tick),
    .limit_i (limit_q),
    .expire_o(expire)
  );

  assign accept    = start_i && (state_q == ST_IDLE);
  assign ack       = (state_q == ST_REQ) && rd_ack_i;
  assign poll_tick = ack || ((state_q == ST_RBWAIT) && !rdy_sync);
  // completion on the last allowed poll beats the timeout
  assign finish_ok = (ack && eval_finish) || ((state_q == ST_RBWAIT) && rdy_sync);
  assign finish_to = poll_tick && expire && !finish_ok;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:   if (accept) state_d = mode_i[1] ? ST_RBWAIT : ST_REQ;
      ST_REQ:    if (ack) state_d = (finish_ok || finish_to) ? ST_IDLE : ST_GAP;
      ST_GAP:    state_d = ST_REQ;
      ST_RBWAIT: if (finish_ok || finish_to) state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q      <= ST_IDLE;
      mode_q       <= MODE_DPOLL;
      erase_q      <= 1'b0;
      exp_bit_q    <= 1'b0;
      addr_q       <= '0;
      limit_q      <= '0;
      confirm_q    <= 1'b0;
      prev_valid_q <= 1'b0;
      prev_bit_q   <= 1'b0;
      done_q       <= 1'b0;
      timeout_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= finish_ok || finish_to;
      if (accept) begin
        mode_q       <= mode_i;
        erase_q      <= op_i;
        exp_bit_q    <= exp_data_i[POLL_BIT];
        addr_q       <= addr_i;
        limit_q      <= max_polls_i;
        confirm_q    <= 1'b0;
        prev_valid_q <= 1'b0;
        prev_bit_q   <= 1'b0;
        timeout_q    <= 1'b0;
      end else begin
        if (ack) begin
          confirm_q    <= (mode_q == MODE_DPOLL) && hit;
          prev_valid_q <= 1'b1;
          prev_bit_q   <= rd_data_i[TOGGLE_BIT];
        end
        if (finish_to) timeout_q <= 1'b1;
      end
    end
  end

  assign rd_req_o  = (state_q == ST_REQ);
  assign rd_addr_o = addr_q;
  assign busy_o    = (state_q != ST_IDLE);
  assign done_o    = done_q;
  assign timeout_o = timeout_q;
endmodule

// File: rtl/flash_poll_ctrl_chk.sv
module flash_poll_ctrl_chk #(
  parameter int unsigned AW = 22
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          start_i,
  input logic          rd_req_o,
  input logic [AW-1:0] rd_addr_o,
  input logic          rd_ack_i,
  input logic          busy_o,
  input logic          done_o,
  input logic          timeout_o,
  input logic          rb_mode_i
);
  // R1
  start_busy_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && start_i |=> $stable(rd_addr_o));
  // R1
  done_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o && !rd_req_o);
  // R2
  req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req_o && !rd_ack_i |=> rd_req_o && $stable(rd_addr_o));
  // R2
  req_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req_o && rd_ack_i |=> !rd_req_o);
  // R7
  rb_no_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && rb_mode_i |-> !rd_req_o);
  // R8
  timeout_with_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(timeout_o) |-> done_o);
  // R9
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R9
  timeout_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o && !start_i |=> $stable(timeout_o));
endmodule

bind flash_poll_ctrl flash_poll_ctrl_chk #(.AW(AW)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .start_i  (start_i),
  .rd_req_o (rd_req_o),
  .rd_addr_o(rd_addr_o),
  .rd_ack_i (rd_ack_i),
  .busy_o   (busy_o),
  .done_o   (done_o),
  .timeout_o(timeout_o),
  .rb_mode_i(mode_q[1])
);

// File: tb/flash_poll_ctrl_bench.sv
`timescale 1ns/1ps
module flash_poll_ctrl_bench;
  localparam int AW = 22, DW = 16, CW = 16;

  logic          clk = 1'b0, rst_n = 1'b0;
  logic          start = 1'b0, op = 1'b0;
  logic [1:0]    mode = 2'b00;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] exp_data = '0;
  logic [CW-1:0] max_polls = '0;
  logic          rd_req, rd_ack = 1'b0, busy, done, timeout;
  logic [AW-1:0] rd_addr;
  logic [DW-1:0] rd_data = '0;
  logic          ready = 1'b1;

  int checks = 0, errors = 0;
  logic [DW-1:0] seq [64];
  int seq_idx = 0, addr_bad = 0;
  logic [AW-1:0] run_addr = '0;

  always #2.5 clk = ~clk;

  flash_poll_ctrl #(.AW(AW), .DW(DW), .CW(CW)) u_flash_poll_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .op_i(op), .mode_i(mode),
    .addr_i(addr), .exp_data_i(exp_data), .max_polls_i(max_polls),
    .rd_req_o(rd_req), .rd_addr_o(rd_addr), .rd_ack_i(rd_ack), .rd_data_i(rd_data),
    .ready_i(ready), .busy_o(busy), .done_o(done), .timeout_o(timeout));

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // memory responder: one-cycle acknowledge after 0..2 cycles
  initial begin
    forever begin
      @(negedge clk);
      if (rd_req && !rd_ack) begin
        repeat ($urandom_range(2)) @(negedge clk);
        if (rd_addr != run_addr) addr_bad++;
        rd_data = seq[seq_idx < 63 ? seq_idx : 63];
        seq_idx++;
        rd_ack = 1'b1;
        @(negedge clk);
        rd_ack = 1'b0;
      end
    end
  end

  // expected outcome of a read-based run from the requirement rules
  task automatic model(input bit tgl, input bit er, input bit e7, input int lim,
                       output int reads, output bit to);
    bit conf = 0, pv = 0, p6 = 0, hit, fin;
    int l = (lim < 1) ? 1 : lim;
    reads = 0; to = 0;
    for (int i = 0; i < 64; i++) begin
      reads = i + 1;
      if (tgl) begin
        hit = pv && (seq[i][6] == p6); fin = hit;
      end else begin
        hit = er ? seq[i][7] : (seq[i][7] == e7); fin = hit && conf; conf = hit;
      end
      pv = 1; p6 = seq[i][6];
      if (fin) return;
      if (reads >= l) begin to = 1; return; end
    end
  endtask

  task automatic run(input logic [1:0] m, input bit o, input logic [DW-1:0] e,
                     input int lim, input bit midstart, output int reads, output bit to,
                     output int cyc, input int rise_at);
    logic [AW-1:0] a = AW'($urandom);
    seq_idx = 0; addr_bad = 0; run_addr = a;
    @(negedge clk);
    mode = m; op = o; exp_data = e; addr = a; max_polls = CW'(lim); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cyc = 1;
    check(busy == 1'b1, "R1", "busy after start", int'(busy), 1);
    while (!done && cyc < 3000) begin
      if (cyc == rise_at) ready = 1'b1;
      if (midstart && cyc == 3) begin
        addr = ~a; mode = ~m; max_polls = '1; start = 1'b1;
      end else start = 1'b0;
      @(negedge clk);
      cyc++;
    end
    start = 1'b0;
    check(done == 1'b1, "R9", "done reached", int'(done), 1);
    reads = seq_idx; to = timeout;
    check(addr_bad == 0, "R2", "read address mismatches", addr_bad, 0);
    @(negedge clk);
    check(done == 1'b0 && busy == 1'b0, "R9", "done single cycle", int'(done), 0);
    check(timeout == to, "R9", "timeout held", int'(timeout), int'(to));
  endtask

  task automatic rd_case(input string req, input logic [1:0] m, input bit o,
                         input logic [DW-1:0] e, input int lim, input bit midstart);
    int r, er, c; bit t, et;
    model(m == 2'b01, o, e[7], lim, er, et);
    run(m, o, e, lim, midstart, r, t, c, -1);
    check(r == er, req, "read count", r, er);
    check(t == et, "R8", "timeout flag", int'(t), int'(et));
  endtask

  task automatic rb_case(input int lim, input int rise);
    int r, c, l, ec; bit t, et;
    l = (lim < 1) ? 1 : lim;
    ready = 1'b0;
    repeat (4) @(negedge clk);
    et = !(rise + 2 <= l);
    ec = et ? l + 1 : rise + 3;
    run(2'b10, 1'b0, '0, lim, 1'b0, r, t, c, rise);
    check(r == 0, "R7", "reads in ready/busy mode", r, 0);
    check(c == ec, "R7", "done latency", c, ec);
    check(t == et, "R8", "ready/busy timeout", int'(t), int'(et));
    ready = 1'b1;
  endtask

  task automatic fill(input int n, input logic [DW-1:0] v [8]);
    for (int i = 0; i < 64; i++) seq[i] = (i < n) ? v[i] : v[n-1];
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run hung, actual done 0 expected 1");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    // R10 reset state
    check(!busy && !done && !timeout && !rd_req, "R10", "reset outputs",
          int'({busy, done, timeout, rd_req}), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R3 program, expected bit7=1, other bits noisy
    fill(4, '{16'h0055, 16'h007f, 16'h00a3, 16'h0080, 0, 0, 0, 0});
    rd_case("R3", 2'b00, 1'b0, 16'h0080, 20, 1'b0);
    // R3 program, expected bit7=0
    fill(3, '{16'h0080, 16'h0012, 16'h0034, 0, 0, 0, 0, 0});
    rd_case("R3", 2'b00, 1'b0, 16'hff7f, 20, 1'b0);
    // R4 erase ignores expected data
    fill(4, '{16'h0000, 16'h0040, 16'h0080, 16'h00ff, 0, 0, 0, 0});
    rd_case("R4", 2'b00, 1'b1, 16'h0000, 20, 1'b0);
    // R5 single-read glitch restarts confirmation
    fill(6, '{16'h0000, 16'h0080, 16'h0000, 16'h0080, 16'h0000, 16'h0080, 0, 0});
    seq[6] = 16'h0080;
    rd_case("R5", 2'b00, 1'b0, 16'h0080, 20, 1'b0);
    // R6 toggle ends on equal bit 6
    fill(4, '{16'h0000, 16'h0040, 16'h0000, 16'h0000, 0, 0, 0, 0});
    rd_case("R6", 2'b01, 1'b0, 16'h0000, 20, 1'b0);
    // R6 first read never completes
    fill(1, '{16'h0040, 0, 0, 0, 0, 0, 0, 0});
    rd_case("R6", 2'b01, 1'b1, 16'h0000, 20, 1'b0);
    // R8 budget exhausted
    fill(1, '{16'h0000, 0, 0, 0, 0, 0, 0, 0});
    rd_case("R8", 2'b00, 1'b0, 16'h0080, 3, 1'b0);
    // R8 zero budget behaves as one
    rd_case("R8", 2'b00, 1'b0, 16'h0080, 0, 1'b0);
    // R8 completion on last allowed poll wins
    fill(1, '{16'h0080, 0, 0, 0, 0, 0, 0, 0});
    rd_case("R8", 2'b00, 1'b0, 16'h0080, 2, 1'b0);
    // R1 start during a run ignored
    fill(5, '{16'h0000, 16'h0000, 16'h0000, 16'h0000, 16'h0080, 0, 0, 0});
    rd_case("R1", 2'b00, 1'b0, 16'h0080, 20, 1'b1);
    // R7 ready/busy success, boundary, timeout, zero budget
    rb_case(20, 5);
    rb_case(7, 5);
    rb_case(6, 5);
    rb_case(0, 50);

    // random sequences
    for (int n = 0; n < 60; n++) begin
      logic [1:0] m = ($urandom_range(1) == 0) ? 2'b00 : 2'b01;
      bit o = 1'($urandom);
      logic [DW-1:0] e = DW'($urandom);
      int busy_len = $urandom_range(12);
      bit b6 = 1'($urandom);
      for (int i = 0; i < 64; i++) begin
        logic [DW-1:0] d = DW'($urandom);
        if (m == 2'b00) begin
          bit good = o ? 1'b1 : e[7];
          d[7] = (i < busy_len) ? ~good : (($urandom_range(5) == 0) ? ~good : good);
        end else begin
          if (i < busy_len || $urandom_range(4) == 0) b6 = ~b6;
          d[6] = b6;
        end
        seq[i] = d;
      end
      rd_case(m == 2'b00 ? "R5" : "R6", m, o, e, $urandom_range(1, 30), 1'($urandom_range(3) == 0));
    end
    for (int n = 0; n < 10; n++) rb_case($urandom_range(1, 25), $urandom_range(1, 30));

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule